// File: doc/BRIEF.md
# Configuration Space Register File

This block holds the standard type-0 configuration header of a bus target together with a small vendor-defined extension area. It is placed behind the bus front end. The front end has already qualified the cycle by its select line and hands over one dword access per request: a four-bit command code, a dword index, active-low byte enables and write data. The block answers with one response per request.

The header contains fixed identification words, writable control fields and a status half-word. The status error flags are raised by one-cycle event inputs from the rest of the target. Software clears them by writing a 1 to each flag. The subsystem identification dword cannot be written at its standard place. Software loads it through an alias dword in the vendor area. A request for a system-error signal on an address parity fault goes out only when a command bit allows it.

Requests and responses use valid/ready. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high whenever no response is pending, or when the pending response is being taken in the same cycle. The response appears on the edge after acceptance. It stays stable until `rsp_ready` is seen high.

Top module: `cfgspace_regfile`

## Requirements
- R1: An accepted request gives `rsp_valid` high from the next edge. While `rsp_ready` is low, `rsp_valid` and `rsp_rdata` hold and `req_ready` is low.
- R2: Only command codes 4'b1010 (read) and 4'b1011 (write) are claimed, and `rsp_hit`=1 for them. Any other code gives `rsp_hit`=0 and `rsp_rdata`=0, and no register changes.
- R3: Index 0 reads 32'h000D_1073. Index 2 reads 32'h0401_0003: revision 03h in byte 0, programming interface 00h in byte 1. Byte 2 of index 3 (header type) reads 00h. Byte 1 of index 15 (interrupt pin) reads 01h. Writes to these fields are ignored.
- R4: The status half-word, in bits 31:16 of index 1, resets to 16'h0210. Bits 4 and 9 always read 1. The other non-flag bits read 0 and cannot be written.
- R5: Status flags sit in bits 15, 14, 13, 12, 11 and 8. `err_evt[0]`, `[1]`, `[2]`, `[3]` and `[4]` set bits 8, 11, 12, 13 and 15. Writing 1 to a flag clears it. When a set and a clear reach the same flag in the same cycle, the flag stays set.
- R6: The command half-word, in bits 15:0 of index 1, resets to 0. Only bits 0, 1, 2, 6 and 8 are writable. A pulse on `addr_perr_evt` while bit 8 is 1 drives `sys_err_req` high for the next cycle and sets status bit 14. While bit 8 is 0, the same pulse does neither.
- R7: The latency byte (bits 15:8 of index 3) and the interrupt-line byte (bits 7:0 of index 15) are read/write and reset to 00h.
- R8: Index 11 (subsystem IDs) resets to 32'h000D_1073 and ignores writes. A write to index 17 updates the value read at index 11. Index 17 reads the same value as index 11.
- R9: Index 16 is fully read/write and resets to 32'h0000_907F. Its low half is the legacy control word and its high half is the extended control word.
- R10: `req_be_n[i]`=0 enables write byte lane i (bits 8i+7:8i). A lane whose enable is 1 keeps its value.
- R11: Indices with no register read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_cmd | input | 4 | Bus command code |
| req_index | input | 6 | Dword index (byte offset / 4) |
| req_be_n | input | 4 | Active-low byte enables |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_hit | output | 1 | Request was claimed |
| rsp_rdata | output | 32 | Read data (0 for writes and unclaimed requests) |
| err_evt | input | 5 | One-cycle status flag set events |
| addr_perr_evt | input | 1 | One-cycle address parity fault event |
| sys_err_req | output | 1 | System-error request, one cycle |

## Verification
The hardest case to reach is a status flag that receives its set event in the same clock as a write-one-to-clear aimed at it. The normal access task cannot line the two up. The bench therefore drives the write request and the event pulse at the same falling edge, outside the task, so both land on one rising edge. A second directed case gates the address parity event first with the command bit cleared and then with it set. This shows that the system-error request and status bit 14 follow the gate, with their timing fixed to the cycle after the pulse.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  localparam logic [3:0] CMD_CFG_RD = 4'b1010;
  localparam logic [3:0] CMD_CFG_WR = 4'b1011;

  localparam int IDX_ID     = 0;
  localparam int IDX_CMDSTS = 1;
  localparam int IDX_CLASS  = 2;
  localparam int IDX_MISC   = 3;
  localparam int IDX_SUBSYS = 11;
  localparam int IDX_INTR   = 15;
  localparam int IDX_LEGACY = 16;
  localparam int IDX_ALIAS  = 17;

  localparam logic [15:0] STS_RO_ONES = 16'h0210;
  localparam logic [15:0] STS_FLAGS   = 16'hF900;
  localparam logic [15:0] CMD_WMASK   = 16'h0147;
endpackage

// File: rtl/cfg_lane_reg.sv
module cfg_lane_reg #(
  parameter int          WIDTH = 32,
  parameter logic [WIDTH-1:0] RESET = '0,
  parameter logic [WIDTH-1:0] WMASK = '1,
  localparam int         LANES = WIDTH / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [LANES-1:0] be_n,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] lane_m;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_m[8*i +: 8] = {8{~be_n[i]}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= RESET;
    else if (wr_en) q <= (q & ~(lane_m & WMASK)) | (wdata & lane_m & WMASK);
  end

  AST_IDLE_LANES_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (&be_n)) |=> $stable(q)); // R10
endmodule

// File: rtl/cfg_status_w1c.sv
module cfg_status_w1c
  import cfg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  be_n,
  input  logic [15:0] wdata,
  input  logic [15:0] set,
  output logic [15:0] rd
);
  logic [15:0] flags_q, clr, set_m;

  assign set_m = set & STS_FLAGS;
  assign clr   = wr_en ? (wdata & {{8{~be_n[1]}}, {8{~be_n[0]}}} & STS_FLAGS) : 16'h0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= 16'h0;
    else        flags_q <= (flags_q & ~clr) | set_m;
  end

  assign rd = flags_q | STS_RO_ONES;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_m != 16'h0) |=> ((rd & $past(set_m)) == $past(set_m))); // R5
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr & ~set_m) != 16'h0) |=> ((rd & $past(clr & ~set_m)) == 16'h0)); // R5
endmodule

// File: rtl/cfgspace_regfile.sv
module cfgspace_regfile
  import cfg_pkg::*;
#(
  parameter int          IDX_W     = 6,
  parameter logic [15:0] VEN_ID    = 16'h1073,
  parameter logic [15:0] DEV_ID    = 16'h000D,
  parameter logic [7:0]  REV_ID    = 8'h03,
  parameter logic [23:0] CLASS     = 24'h040100,
  parameter logic [15:0] SUBSYS_ID = 16'h000D,
  parameter logic [31:0] LEGACY_RST = 32'h0000_907F
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [3:0]       req_cmd,
  input  logic [IDX_W-1:0] req_index,
  input  logic [3:0]       req_be_n,
  input  logic [31:0]      req_wdata,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic             rsp_hit,
  output logic [31:0]      rsp_rdata,
  input  logic [4:0]       err_evt,
  input  logic             addr_perr_evt,
  output logic             sys_err_req
);
  logic        accept, is_rd, is_wr, hit, wr;
  logic [15:0] cmd_q, sts_rd, sts_set;
  logic [31:0] lat_q, intr_q, legacy_q, ssid_q, rd_mux;
  logic        sys_err_fire;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign is_rd     = (req_cmd == CMD_CFG_RD);
  assign is_wr     = (req_cmd == CMD_CFG_WR);
  assign hit       = is_rd || is_wr;
  assign wr        = accept && is_wr;

  cfg_lane_reg #(.WIDTH(16), .RESET(16'h0), .WMASK(CMD_WMASK)) u_cmd (
    .clk, .rst_n, .wr_en(wr && req_index == IDX_W'(IDX_CMDSTS)),
    .be_n(req_be_n[1:0]), .wdata(req_wdata[15:0]), .q(cmd_q));

  cfg_lane_reg #(.WIDTH(32), .RESET(32'h0), .WMASK(32'h0000_FF00)) u_lat (
    .clk, .rst_n, .wr_en(wr && req_index == IDX_W'(IDX_MISC)),
    .be_n(req_be_n), .wdata(req_wdata), .q(lat_q));

  cfg_lane_reg #(.WIDTH(32), .RESET(32'h0000_0100), .WMASK(32'h0000_00FF)) u_intr (
    .clk, .rst_n, .wr_en(wr && req_index == IDX_W'(IDX_INTR)),
    .be_n(req_be_n), .wdata(req_wdata), .q(intr_q));

  cfg_lane_reg #(.WIDTH(32), .RESET(LEGACY_RST), .WMASK(32'hFFFF_FFFF)) u_legacy (
    .clk, .rst_n, .wr_en(wr && req_index == IDX_W'(IDX_LEGACY)),
    .be_n(req_be_n), .wdata(req_wdata), .q(legacy_q));

  cfg_lane_reg #(.WIDTH(32), .RESET({SUBSYS_ID, VEN_ID}), .WMASK(32'hFFFF_FFFF)) u_ssid (
    .clk, .rst_n, .wr_en(wr && req_index == IDX_W'(IDX_ALIAS)),
    .be_n(req_be_n), .wdata(req_wdata), .q(ssid_q));

  assign sys_err_fire = addr_perr_evt && cmd_q[8];
  assign sts_set = {err_evt[4], sys_err_fire, err_evt[3], err_evt[2], err_evt[1],
                    2'b00, err_evt[0], 8'h00};

  cfg_status_w1c u_sts (
    .clk, .rst_n, .wr_en(wr && req_index == IDX_W'(IDX_CMDSTS)),
    .be_n(req_be_n[3:2]), .wdata(req_wdata[31:16]), .set(sts_set), .rd(sts_rd));

  always_comb begin
    case (req_index)
      IDX_W'(IDX_ID):                     rd_mux = {DEV_ID, VEN_ID};
      IDX_W'(IDX_CMDSTS):                 rd_mux = {sts_rd, cmd_q};
      IDX_W'(IDX_CLASS):                  rd_mux = {CLASS, REV_ID};
      IDX_W'(IDX_MISC):                   rd_mux = lat_q;
      IDX_W'(IDX_SUBSYS), IDX_W'(IDX_ALIAS): rd_mux = ssid_q;
      IDX_W'(IDX_INTR):                   rd_mux = intr_q;
      IDX_W'(IDX_LEGACY):                 rd_mux = legacy_q;
      default:                            rd_mux = 32'h0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_hit     <= 1'b0;
      rsp_rdata   <= 32'h0;
      sys_err_req <= 1'b0;
    end else begin
      sys_err_req <= sys_err_fire;
      if (accept) begin
        rsp_valid <= 1'b1;
        rsp_hit   <= hit;
        rsp_rdata <= is_rd ? rd_mux : 32'h0;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_hit))); // R1
  AST_UNCLAIMED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !hit) |=> (rsp_valid && !rsp_hit && rsp_rdata == 32'h0 && $stable(legacy_q))); // R2
  AST_ID_CONST: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_rd && req_index == IDX_W'(IDX_ID)) |=> (rsp_rdata == {DEV_ID, VEN_ID})); // R3
  AST_SERR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    sys_err_req |-> $past(addr_perr_evt)); // R6
endmodule

// File: tb/cfgspace_regfile_test.sv
`timescale 1ns/1ps
module cfgspace_regfile_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0, rsp_ready = 1'b1, addr_perr_evt = 1'b0;
  logic [3:0]  req_cmd = 4'h0, req_be_n = 4'hF;
  logic [5:0]  req_index = '0;
  logic [31:0] req_wdata = '0;
  logic [4:0]  err_evt = '0;
  logic        req_ready, rsp_valid, rsp_hit, sys_err_req;
  logic [31:0] rsp_rdata;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  localparam logic [3:0] RD = 4'b1010, WR = 4'b1011;

  always #2 clk = ~clk;

  cfgspace_regfile uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic acc(input logic [3:0] cmd, input logic [5:0] idx, input logic [3:0] ben,
                     input logic [31:0] wd, output logic [31:0] rd, output logic h);
    @(negedge clk);
    req_valid = 1; req_cmd = cmd; req_index = idx; req_be_n = ben; req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    rd = rsp_rdata; h = rsp_hit;
  endtask

  task automatic rd32(input logic [5:0] idx, output logic [31:0] d);
    logic h;
    acc(RD, idx, 4'h0, 32'h0, d, h);
  endtask

  task automatic wr32(input logic [5:0] idx, input logic [3:0] ben, input logic [31:0] wd);
    logic [31:0] d; logic h;
    acc(WR, idx, ben, wd, d, h);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd32(1, d);  chk("R4 status/command reset", d, 32'h0210_0000);
    rd32(16, d); chk("R9 legacy reset", d, 32'h0000_907F);
    rd32(11, d); chk("R8 subsystem reset", d, 32'h000D_1073);
    rd32(15, d); chk("R7 intr reset", d, 32'h0000_0100);
    rd32(3, d);  chk("R7 latency reset", d, 32'h0);
    rd32(2, d);  chk("R3 class/rev", d, 32'h0401_0003);
  endtask

  task automatic t_ids;
    logic [31:0] d;
    wr32(0, 4'h0, 32'hFFFF_FFFF); rd32(0, d); chk("R3 id write ignored", d, 32'h000D_1073);
    wr32(2, 4'h0, 32'hFFFF_FFFF); rd32(2, d); chk("R3 class write ignored", d, 32'h0401_0003);
  endtask

  task automatic t_unclaimed;
    logic [31:0] d; logic h;
    acc(4'b0110, 0, 4'h0, 32'h0, d, h);
    chk("R2 unclaimed hit", {31'h0, h}, 32'h0);
    chk("R2 unclaimed data", d, 32'h0);
    acc(4'b0000, 16, 4'h0, 32'h0, d, h);
    rd32(16, d); chk("R2 unclaimed write no effect", d, 32'h0000_907F);
    acc(RD, 0, 4'h0, 32'h0, d, h);
    chk("R2 cfg read hit", {31'h0, h}, 32'h1);
  endtask

  task automatic t_lanes;
    logic [31:0] d;
    wr32(16, 4'b1110, 32'h1234_5678); rd32(16, d); chk("R10 lane0 only", d, 32'h0000_9078);
    wr32(16, 4'b0011, 32'hAABB_CCDD); rd32(16, d); chk("R10 R9 lanes 2,3", d, 32'hAABB_9078);
    wr32(16, 4'h0, 32'h0);            rd32(16, d); chk("R9 full write", d, 32'h0);
  endtask

  task automatic t_latency;
    logic [31:0] d;
    wr32(3, 4'h0, 32'hFFFF_FFFF);  rd32(3, d);  chk("R7 latency rw", d, 32'h0000_FF00);
    wr32(15, 4'h0, 32'hFFFF_FFFF); rd32(15, d); chk("R7 R3 intr line rw, pin fixed", d, 32'h0000_01FF);
  endtask

  task automatic t_command;
    logic [31:0] d;
    wr32(1, 4'b1100, 32'hFFFF_FFFF); rd32(1, d); chk("R6 command mask", d, 32'h0210_0147);
  endtask

  task automatic t_status;
    logic [31:0] d;
    @(negedge clk); err_evt = 5'b11111;
    @(negedge clk); err_evt = 5'b00000;
    rd32(1, d); chk("R5 flags set by events", d, 32'hBB10_0147);
    wr32(1, 4'b0011, 32'h2800_0000); rd32(1, d); chk("R5 w1c bits 13,11", d, 32'h9310_0147);
    wr32(1, 4'b0011, 32'h0210_0000); rd32(1, d); chk("R4 fixed bits unaffected", d, 32'h9310_0147);
  endtask

  task automatic t_set_wins;
    logic [31:0] d;
    @(negedge clk);
    req_valid = 1; req_cmd = WR; req_index = 1; req_be_n = 4'b0011; req_wdata = 32'h8000_0000;
    err_evt = 5'b10000;
    @(negedge clk);
    req_valid = 0; err_evt = 5'b00000;
    rd32(1, d); chk("R5 set wins over clear", d, 32'h9310_0147);
    wr32(1, 4'b0011, 32'h9100_0000); rd32(1, d); chk("R5 w1c all", d, 32'h0210_0147);
  endtask

  task automatic t_serr;
    logic [31:0] d;
    wr32(1, 4'b1100, 32'h0000_0000);
    @(negedge clk); addr_perr_evt = 1;
    @(negedge clk); addr_perr_evt = 0;
    chk("R6 gated off no request", {31'h0, sys_err_req}, 32'h0);
    rd32(1, d); chk("R6 gated off no flag", d, 32'h0210_0000);
    wr32(1, 4'b1100, 32'h0000_0100);
    @(negedge clk); addr_perr_evt = 1;
    @(negedge clk); addr_perr_evt = 0;
    chk("R6 request raised", {31'h0, sys_err_req}, 32'h1);
    @(negedge clk);
    chk("R6 request one cycle", {31'h0, sys_err_req}, 32'h0);
    rd32(1, d); chk("R6 flag 14 set", d, 32'h4210_0100);
  endtask

  task automatic t_subsys;
    logic [31:0] d;
    wr32(11, 4'h0, 32'hFFFF_FFFF); rd32(11, d); chk("R8 direct write ignored", d, 32'h000D_1073);
    wr32(17, 4'h0, 32'h1234_5678); rd32(11, d); chk("R8 alias loads", d, 32'h1234_5678);
    rd32(17, d); chk("R8 alias mirrors", d, 32'h1234_5678);
    wr32(17, 4'b1110, 32'h0000_00AA); rd32(11, d); chk("R8 R10 alias byte write", d, 32'h1234_56AA);
  endtask

  task automatic t_unimpl;
    logic [31:0] d;
    rd32(5, d); chk("R11 hole reads zero", d, 32'h0);
    wr32(20, 4'h0, 32'hFFFF_FFFF); rd32(20, d); chk("R11 hole write no effect", d, 32'h0);
    rd32(63, d); chk("R11 top index zero", d, 32'h0);
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    rsp_ready = 0; req_valid = 1; req_cmd = RD; req_index = 16; req_be_n = 4'h0;
    @(negedge clk);
    req_valid = 0;
    chk("R1 response valid", {31'h0, rsp_valid}, 32'h1);
    repeat (3) @(negedge clk);
    chk("R1 held valid", {31'h0, rsp_valid}, 32'h1);
    chk("R1 held data", rsp_rdata, 32'h0);
    chk("R1 not ready", {31'h0, req_ready}, 32'h0);
    rsp_ready = 1;
    @(negedge clk);
    chk("R1 released", {31'h0, rsp_valid}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset(); t_ids(); t_unclaimed(); t_lanes(); t_latency();
    t_command(); t_status(); t_set_wins(); t_serr(); t_subsys();
    t_unimpl(); t_backpressure();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule